// File: doc/BRIEF.md
# Receive word queue with idle-flush ready flag

This block sits between a serial receiver and the register read port of a UART. Each received word enters a small first-in first-out store together with four status bits describing how it arrived: frame error, parity error, noise, and whether the line was idle just before it. The read side sees the oldest word and its status at all times, and a read strobe removes it. An empty indication marks the presented word as invalid when nothing is stored.

Software decides when to service the queue through a single data-ready flag. The flag rises when the stored count exceeds a programmable watermark. It also rises when the line has been quiet for a programmable number of idle characters (1 to 64, in powers of two) while at least one word is waiting. This lets a short final burst be collected without waiting for the watermark. A configuration bit reduces the queue to a single-entry buffer. The block also provides a flush control and sticky overrun and underflow flags. The underflow flag can raise an interrupt.

Top module: `rx_idle_fifo`

## Requirements
- R1: With `cfg_fifo_en`=1 the block stores up to DEPTH (default 4) words. Reads return them oldest first, and `count` reports the number stored.
- R2: With `cfg_fifo_en`=0 the block stores at most one word.
- R3: A word is accepted only if, after any read in the same cycle, the stored count is below the capacity. Otherwise the word is dropped and `overrun` is set. `overrun` stays set until a `clr_overrun` pulse, and a set in the same cycle as a clear wins.
- R4: The frame, parity, noise and idle-before bits presented with a word come back unchanged on the read side alongside that word.
- R5: `rd_empty` is 1 exactly when `count` is 0. A read strobe while empty sets the sticky `underflow` flag, which `clr_underflow` clears (a set wins over a clear). `uflow_irq` equals `underflow` AND `cfg_uflow_ie`.
- R6: A `flush` pulse empties the store in one cycle and restarts the idle counter. A read or a write in the same cycle is ignored.
- R7: `data_ready` is 1 whenever `count` is greater than `cfg_watermark`.
- R8: With `cfg_idle_sel`=n, where n is from 1 to 7, `data_ready` is also 1 once 2^(n-1) idle ticks have arrived since the last received word or flush, provided `count` is at least 1. With n=0 the idle path is off.
- R9: Every received word restarts the idle count, even a dropped word, and this takes precedence over an idle tick in the same cycle. The count saturates at 64.
- R10: All state changes on the rising clock edge and is visible on the outputs right after that edge. Reset empties the store, clears both flags and clears the idle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fifo_en | input | 1 | 1: full depth, 0: single-entry buffer |
| cfg_watermark | input | 8 | Count threshold for data-ready |
| cfg_idle_sel | input | 3 | Idle timeout select, 0 disables |
| cfg_uflow_ie | input | 1 | Underflow interrupt enable |
| wr_valid | input | 1 | Received-word strobe |
| wr_data | input | 10 | Received data word |
| wr_frame_err | input | 1 | Frame error of the word |
| wr_parity_err | input | 1 | Parity error of the word |
| wr_noise | input | 1 | Noise seen on the word |
| wr_idle_before | input | 1 | Line idle before the word |
| idle_tick | input | 1 | One idle character elapsed |
| rd_strobe | input | 1 | Remove the oldest word |
| flush | input | 1 | Discard all stored words |
| clr_underflow | input | 1 | Clear underflow flag |
| clr_overrun | input | 1 | Clear overrun flag |
| rd_data | output | 10 | Oldest stored word |
| rd_frame_err | output | 1 | Frame error of oldest word |
| rd_parity_err | output | 1 | Parity error of oldest word |
| rd_noise | output | 1 | Noise of oldest word |
| rd_idle_before | output | 1 | Idle-before of oldest word |
| rd_empty | output | 1 | No valid word present |
| count | output | 8 | Stored word count |
| data_ready | output | 1 | Service request flag |
| underflow | output | 1 | Sticky underflow flag |
| overrun | output | 1 | Sticky overrun flag |
| uflow_irq | output | 1 | Underflow interrupt |

## Verification
The queue is first filled to capacity and one word beyond it, then drained and read once more while empty. This separates correct ordering from overrun and underflow handling. A simultaneous read and write on a full queue shows whether the pop is credited before the capacity test. Idle ticks under several timeout settings, interleaved with new words, show whether the timeout threshold, the restart and the need for a non-empty store are all honoured. A long random run then mixes every control, including mode and watermark changes with words stored, against a queue-based model.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   typedef struct packed {
      logic idle_before;
      logic noise;
      logic parity_err;
      logic frame_err;
   } rxq_flags_t;

   localparam int FLAGS_W = $bits(rxq_flags_t);

   // number of idle characters selected by a timeout code (code 0 unused)
   function automatic int unsigned idle_limit(input int unsigned code);
      if (code == 0) return 0;
      return 1 << (code - 1);
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
   import rxq_pkg::*;
#(
   parameter int DATA_W = 10,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              flush,
   input  logic              push_req,
   input  logic [DATA_W-1:0] push_data,
   input  rxq_flags_t        push_flags,
   input  logic              pop_req,
   output logic [DATA_W-1:0] head_data,
   output rxq_flags_t        head_flags,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic              empty,
   output logic              dropped
);
   localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int LVL_W   = $clog2(DEPTH+1);
   localparam int ENTRY_W = DATA_W + FLAGS_W;
   localparam logic [LVL_W-1:0] CAP_FULL = LVL_W'(DEPTH);
   localparam logic [LVL_W-1:0] CAP_ONE  = LVL_W'(1);

   logic [ENTRY_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]   wr_ptr, rd_ptr;
   logic [LVL_W-1:0]   lvl_q;
   logic [LVL_W-1:0]   cap;
   logic [LVL_W-1:0]   lvl_after_pop;
   logic               do_pop, do_push;

   assign cap           = fifo_en ? CAP_FULL : CAP_ONE;
   assign empty         = (lvl_q == '0);
   assign do_pop        = pop_req && !empty && !flush;
   assign lvl_after_pop = lvl_q - LVL_W'(do_pop);
   assign do_push       = push_req && !flush && (lvl_after_pop < cap);
   assign dropped       = push_req && !flush && !(lvl_after_pop < cap);

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      if (DEPTH == 1) return '0;
      if (p == PTR_W'(DEPTH-1)) return '0;
      return p + PTR_W'(1);
   endfunction

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[gi] <= '0;
            end else if (do_push && (wr_ptr == PTR_W'(gi))) begin
               mem[gi] <= {push_flags, push_data};
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         lvl_q  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         lvl_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= ptr_next(wr_ptr);
         if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
         lvl_q <= lvl_after_pop + LVL_W'(do_push);
      end
   end

   assign {head_flags, head_data} = mem[rd_ptr];
   assign level = lvl_q;

   initial begin
      if (DATA_W < 1) $error("rxq_store: DATA_W must be positive");
      if (DEPTH < 1)  $error("rxq_store: DEPTH must be positive");
   end

   assert_level_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= CAP_FULL);

   assert_legacy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && lvl_q == CAP_ONE && push_req && !pop_req && !flush) |=> (lvl_q == CAP_ONE));

   assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer
   import rxq_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel,
   input  logic             restart,
   input  logic             tick,
   output logic             expired
);
   localparam int MAX_CODE = (1 << SEL_W) - 1;
   localparam int MAX_LIM  = 1 << (MAX_CODE - 1);
   localparam int CNT_W    = $clog2(MAX_LIM + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != CNT_W'(MAX_LIM))) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign limit   = CNT_W'(idle_limit(int'(sel)));
   assign expired = (sel != '0) && (cnt_q >= limit);

   initial begin
      if (SEL_W < 1 || SEL_W > 4) $error("rxq_idle_timer: SEL_W must be 1 to 4");
   end

   assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !expired);

   assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_W'(MAX_LIM) && !restart) |=> (cnt_q == CNT_W'(MAX_LIM)));
endmodule

// File: rtl/rxq_sticky.sv
module rxq_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/rx_idle_fifo.sv
module rx_idle_fifo
   import rxq_pkg::*;
#(
   parameter int DATA_W    = 10,
   parameter int DEPTH     = 4,
   parameter int CNT_W     = 8,
   parameter int IDLE_SEL_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_fifo_en,
   input  logic [CNT_W-1:0]      cfg_watermark,
   input  logic [IDLE_SEL_W-1:0] cfg_idle_sel,
   input  logic                  cfg_uflow_ie,
   input  logic                  wr_valid,
   input  logic [DATA_W-1:0]     wr_data,
   input  logic                  wr_frame_err,
   input  logic                  wr_parity_err,
   input  logic                  wr_noise,
   input  logic                  wr_idle_before,
   input  logic                  idle_tick,
   input  logic                  rd_strobe,
   input  logic                  flush,
   input  logic                  clr_underflow,
   input  logic                  clr_overrun,
   output logic [DATA_W-1:0]     rd_data,
   output logic                  rd_frame_err,
   output logic                  rd_parity_err,
   output logic                  rd_noise,
   output logic                  rd_idle_before,
   output logic                  rd_empty,
   output logic [CNT_W-1:0]      count,
   output logic                  data_ready,
   output logic                  underflow,
   output logic                  overrun,
   output logic                  uflow_irq
);
   localparam int LVL_W = $clog2(DEPTH+1);

   rxq_flags_t       in_flags, out_flags;
   logic [LVL_W-1:0] level;
   logic             dropped, idle_expired, uflow_set;

   assign in_flags = '{idle_before: wr_idle_before, noise: wr_noise,
                       parity_err: wr_parity_err, frame_err: wr_frame_err};

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .fifo_en    (cfg_fifo_en),
      .flush      (flush),
      .push_req   (wr_valid),
      .push_data  (wr_data),
      .push_flags (in_flags),
      .pop_req    (rd_strobe),
      .head_data  (rd_data),
      .head_flags (out_flags),
      .level      (level),
      .empty      (rd_empty),
      .dropped    (dropped)
   );

   rxq_idle_timer #(.SEL_W(IDLE_SEL_W)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (cfg_idle_sel),
      .restart (wr_valid || flush),
      .tick    (idle_tick),
      .expired (idle_expired)
   );

   assign uflow_set = rd_strobe && rd_empty && !flush;

   rxq_sticky u_uflow (
      .clk (clk), .rst_n (rst_n), .set (uflow_set), .clr (clr_underflow), .q (underflow)
   );

   rxq_sticky u_oflow (
      .clk (clk), .rst_n (rst_n), .set (dropped), .clr (clr_overrun), .q (overrun)
   );

   generate
      if (CNT_W > LVL_W) begin : g_cnt_wide
         assign count = {{(CNT_W-LVL_W){1'b0}}, level};
      end else begin : g_cnt_exact
         assign count = CNT_W'(level);
      end
   endgenerate

   assign rd_frame_err   = out_flags.frame_err;
   assign rd_parity_err  = out_flags.parity_err;
   assign rd_noise       = out_flags.noise;
   assign rd_idle_before = out_flags.idle_before;

   assign data_ready = (count > cfg_watermark) || (idle_expired && !rd_empty);
   assign uflow_irq  = underflow && cfg_uflow_ie;

   initial begin
      if (CNT_W < LVL_W) $error("rx_idle_fifo: CNT_W too narrow for DEPTH");
   end

   assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !flush && !rd_strobe && count == CNT_W'(DEPTH)) |=> overrun);

   assert_underflow_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && rd_empty && !flush) |=> underflow);

   assert_empty_matches_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_empty == (count == '0));
endmodule

// File: tb/tb_rx_idle_fifo.sv
`timescale 1ns/1ps
module tb_rx_idle_fifo;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       cfg_fifo_en = 1'b1;
   logic [7:0] cfg_watermark = 8'd0;
   logic [2:0] cfg_idle_sel = 3'd0;
   logic       cfg_uflow_ie = 1'b0;
   logic       wr_valid = 0, idle_tick = 0, rd_strobe = 0, flush = 0;
   logic       clr_underflow = 0, clr_overrun = 0;
   logic [9:0] wr_data = '0;
   logic [3:0] wr_fl = '0;  // {idle_before, noise, parity, frame}

   logic [9:0] rd_data;
   logic rd_frame_err, rd_parity_err, rd_noise, rd_idle_before, rd_empty;
   logic [7:0] count;
   logic data_ready, underflow, overrun, uflow_irq;

   rx_idle_fifo dut (
      .clk(clk), .rst_n(rst_n), .cfg_fifo_en(cfg_fifo_en), .cfg_watermark(cfg_watermark),
      .cfg_idle_sel(cfg_idle_sel), .cfg_uflow_ie(cfg_uflow_ie), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_frame_err(wr_fl[0]), .wr_parity_err(wr_fl[1]),
      .wr_noise(wr_fl[2]), .wr_idle_before(wr_fl[3]), .idle_tick(idle_tick),
      .rd_strobe(rd_strobe), .flush(flush), .clr_underflow(clr_underflow),
      .clr_overrun(clr_overrun), .rd_data(rd_data), .rd_frame_err(rd_frame_err),
      .rd_parity_err(rd_parity_err), .rd_noise(rd_noise), .rd_idle_before(rd_idle_before),
      .rd_empty(rd_empty), .count(count), .data_ready(data_ready), .underflow(underflow),
      .overrun(overrun), .uflow_irq(uflow_irq)
   );

   // reference model
   logic [13:0] mq[$];
   int  m_idle = 0;
   bit  m_uf = 0, m_ov = 0;
   int  total = 0, bad = 0;

   task automatic chk(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_step();
      int cap;
      bit pop, uset, oset;
      uset = 0; oset = 0;
      if (flush) begin
         mq.delete();
         m_idle = 0;
      end else begin
         pop = rd_strobe && mq.size() > 0;
         if (rd_strobe && mq.size() == 0) uset = 1;
         if (pop) void'(mq.pop_front());
         cap = cfg_fifo_en ? 4 : 1;
         if (wr_valid) begin
            if (mq.size() < cap) mq.push_back({wr_fl, wr_data});
            else oset = 1;
         end
      end
      if (wr_valid || flush) m_idle = 0;
      else if (idle_tick && m_idle < 64) m_idle++;
      if (uset) m_uf = 1; else if (clr_underflow) m_uf = 0;
      if (oset) m_ov = 1; else if (clr_overrun) m_ov = 0;
   endtask

   task automatic compare();
      bit exp_dr;
      int n;
      n = mq.size();
      exp_dr = (n > int'(cfg_watermark)) ||
               (cfg_idle_sel != 0 && m_idle >= (1 << (cfg_idle_sel - 1)) && n > 0);
      chk("R1 count", int'(count), n);
      chk("R5 rd_empty", int'(rd_empty), int'(n == 0));
      if (n > 0) begin
         chk("R1 rd_data order", int'(rd_data), int'(mq[0][9:0]));
         chk("R4 status bits",
             int'({rd_idle_before, rd_noise, rd_parity_err, rd_frame_err}), int'(mq[0][13:10]));
      end
      chk("R7 R8 data_ready", int'(data_ready), int'(exp_dr));
      chk("R5 underflow", int'(underflow), int'(m_uf));
      chk("R5 uflow_irq", int'(uflow_irq), int'(m_uf && cfg_uflow_ie));
      chk("R3 overrun", int'(overrun), int'(m_ov));
   endtask

   // one clock: inputs already driven at negedge
   task automatic cyc();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      wr_valid = 0; idle_tick = 0; rd_strobe = 0; flush = 0;
      clr_underflow = 0; clr_overrun = 0;
   endtask

   task automatic push(input logic [9:0] d, input logic [3:0] f);
      wr_valid = 1; wr_data = d; wr_fl = f; cyc();
   endtask

   task automatic pop();
      rd_strobe = 1; cyc();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin idle_tick = 1; cyc(); end
   endtask

   initial begin
      #(200000 * 4);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      compare();  // R10 reset state
      chk("R10 reset count", int'(count), 0);

      // R1: fill and drain in order, R4 flags
      cfg_watermark = 8'd3;
      push(10'h101, 4'b0001); push(10'h202, 4'b0010);
      push(10'h303, 4'b0100); push(10'h3FF, 4'b1000);
      chk("R7 ready above watermark", int'(data_ready), 1);
      // R3: fifth word dropped
      push(10'h055, 4'b1111);
      chk("R3 overrun after drop", int'(overrun), 1);
      // R3: read+write while full accepted
      wr_valid = 1; wr_data = 10'h066; wr_fl = 4'b0101; rd_strobe = 1; cyc();
      chk("R3 count stays full", int'(count), 4);
      clr_overrun = 1; cyc();
      chk("R3 overrun cleared", int'(overrun), 0);
      pop(); pop(); pop(); pop();
      // R5: underflow and irq
      pop();
      chk("R5 underflow set", int'(underflow), 1);
      cfg_uflow_ie = 1; cyc();
      chk("R5 irq enabled", int'(uflow_irq), 1);
      rd_strobe = 1; clr_underflow = 1; cyc();
      chk("R5 set beats clear", int'(underflow), 1);
      clr_underflow = 1; cyc();

      // R2: legacy mode
      cfg_fifo_en = 0;
      push(10'h011, 4'b0000); push(10'h022, 4'b0000);
      chk("R2 legacy holds one", int'(count), 1);
      pop();
      cfg_fifo_en = 1; clr_overrun = 1; cyc();

      // R8: idle timeout with several settings
      cfg_watermark = 8'd3;
      for (int s = 1; s <= 7; s += 3) begin
         cfg_idle_sel = 3'(s);
         push(10'h0A0 + 10'(s), 4'b0000);
         ticks((1 << (s - 1)) - 1);
         chk("R8 not yet ready", int'(data_ready), 0);
         ticks(1);
         chk("R8 ready after idle", int'(data_ready), 1);
         // R9: new word restarts the count
         wr_valid = 1; wr_data = 10'h1C0; idle_tick = 1; cyc();
         chk("R9 restart on word", int'(data_ready), 0);
         rd_strobe = 1; flush = 1; cyc();  // R6 flush overrides read
         chk("R6 flushed", int'(count), 0);
         chk("R6 no underflow on flush", int'(underflow), 0);
      end
      // R8: timeout with empty store does not assert
      cfg_idle_sel = 3'd1; ticks(3);
      chk("R8 empty not ready", int'(data_ready), 0);
      cfg_idle_sel = 3'd0; push(10'h3A5, 4'b1010); ticks(70);
      chk("R8 disabled", int'(data_ready), 0);
      cfg_idle_sel = 3'd7; cyc();
      chk("R9 saturated count still expired", int'(data_ready), 1);
      // R6: flush with concurrent write
      wr_valid = 1; wr_data = 10'h111; flush = 1; cyc();
      chk("R6 write ignored during flush", int'(count), 0);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         if (i % 97 == 0) begin
            cfg_fifo_en   = ($urandom_range(0, 3) != 0);
            cfg_watermark = 8'($urandom_range(0, 4));
            cfg_idle_sel  = 3'($urandom_range(0, 7));
            cfg_uflow_ie  = 1'($urandom_range(0, 1));
         end
         wr_valid  = ($urandom_range(0, 2) == 0);
         wr_data   = 10'($urandom);
         wr_fl     = 4'($urandom);
         rd_strobe = ($urandom_range(0, 2) == 0);
         idle_tick = ($urandom_range(0, 1) == 0);
         flush     = ($urandom_range(0, 60) == 0);
         clr_underflow = ($urandom_range(0, 10) == 0);
         clr_overrun   = ($urandom_range(0, 10) == 0);
         cyc();
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule